// File: doc/BRIEF.md
# Array Bounds Check Unit

This unit decides whether a signed index lies inside an inclusive range whose two limits are stored in memory as a pair of consecutive words. The caller supplies four things: an effective address, the index value, the operand size (16 or 32 bits) and the two-bit addressing-mode field of the operand. The unit then reads the lower limit at the effective address. After that it reads the upper limit from the word that follows. When both limits are in hand, it reports one of four outcomes: the index passed, the index is out of range (with interrupt vector 5), the operand was a register form and is illegal, or a memory read aborted.

Memory is reached through a simple read port. A request is a single-cycle strobe with an address and a size bit. The answer comes back on a later cycle as a valid strobe, carrying either data or an abort flag. A fast-timing input picks between two fixed completion latencies, so the caller sees a predictable cycle count when memory answers promptly.

Top module: `bound_check_unit`

## Requirements
- R1: When `modField` is 2'b11 at start, the unit issues no memory request, raises `illegalOp` and pulses `done` exactly one cycle after the start edge.
- R2: The unit reads the lower limit at `effAddr` first. It then reads the upper limit at `effAddr`+2 when `opWide`=0 and at `effAddr`+4 when `opWide`=1. `memWide` equals `opWide`, each `memReq` lasts one cycle, and a second request is issued only after the first has been answered.
- R3: Comparisons are signed at the operand width. In 16-bit mode only bits [15:0] of the index and of each memory word count, and bit 15 is the sign.
- R4: An index below the lower limit or above the upper limit gives `boundTrap`=1 and `trapVector`=5. An index equal to either limit, or between them, gives `passOk`=1 and `trapVector`=0.
- R5: If each read is answered on the cycle after its request, `done` for a pass or trap rises exactly 10 cycles after the start edge with `fastMode`=0, and 7 cycles after with `fastMode`=1. Slower memory only delays the result.
- R6: A response with `memAbort`=1 ends the operation at once: no further request is made, `abortOut` is raised, no verdict is given, and `done` pulses on the edge that takes the response.
- R7: `busy` is high from the start edge until the edge that raises `done`. A `start` seen while busy is ignored.
- R8: After reset all outputs are low. `done` is a one-cycle pulse. On `done`, exactly one of `passOk`, `boundTrap`, `illegalOp` and `abortOut` is high, and it stays so until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a check (sampled while idle) |
| opWide | input | 1 | 1 = 32-bit operand, 0 = 16-bit |
| fastMode | input | 1 | 1 selects the 7-cycle latency, 0 the 10-cycle one |
| modField | input | 2 | Operand addressing mode; 2'b11 is register form |
| effAddr | input | ADDR_W | Address of the lower limit |
| indexVal | input | DATA_W | Index to test |
| memReq | output | 1 | Read request strobe |
| memAddr | output | ADDR_W | Read address |
| memWide | output | 1 | Read size, 1 = 32 bits |
| memValid | input | 1 | Read response strobe |
| memAbort | input | 1 | Response carries an abort |
| memData | input | DATA_W | Read data |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| passOk | output | 1 | Index within limits |
| boundTrap | output | 1 | Index out of range |
| illegalOp | output | 1 | Register-form operand |
| abortOut | output | 1 | A read aborted |
| trapVector | output | 8 | 5 on a range trap, else 0 |

## Verification
The bench covers the following corner cases:
- Limits that are negative in 16-bit mode while garbage sits in the upper memory bits. A design that compares unsigned, or at 32 bits, passes or traps the wrong indices.
- Indices exactly equal to each limit, and the most negative and most positive 32-bit values. An off-by-one comparison shows up here as a false trap.
- Register-form operands and aborts on the first and on the second read. A design that leaks a request or a verdict shows it in the request count and in the outcome flags.
- Cycle counts in both timing modes, a slow memory, and a start pulse injected mid-operation. These expose padding that is wrong, padding that cannot stretch, and restarts that should not happen.

// File: rtl/bcu_pkg.sv
package bcu_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_ISSUE_LO,
    S_WAIT_LO,
    S_ISSUE_HI,
    S_WAIT_HI,
    S_SETTLE,
    S_REPORT
  } bcuState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadOp;
    logic selHi;
    logic captureLo;
    logic captureHi;
    logic setIllegal;
    logic setAbort;
    logic setVerdict;
  } bcuCtl_t;

  localparam logic [7:0] RANGE_VECTOR = 8'd5;
  localparam logic [1:0] MOD_REGISTER = 2'b11;

endpackage

// File: rtl/bcu_ctrl.sv
module bcu_ctrl
  import bcu_pkg::*;
#(
  parameter int SLOW_LAT = 10,
  parameter int FAST_LAT = 7
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic [1:0] modField,
  input  logic       fastMode,
  input  logic       memValid,
  input  logic       memAbort,
  output bcuCtl_t    ctl,
  output logic       memReq,
  output logic       busy,
  output logic       done
);

  localparam int MAX_LAT = (SLOW_LAT > FAST_LAT) ? SLOW_LAT : FAST_LAT;
  localparam int CNT_W   = $clog2(MAX_LAT + 1);
  localparam logic [CNT_W-1:0] CNT_MAX  = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] SLOW_CNT = CNT_W'(SLOW_LAT);
  localparam logic [CNT_W-1:0] FAST_CNT = CNT_W'(FAST_LAT);

  bcuState_e state, nxtState;
  logic [CNT_W-1:0] latCnt, latTarget;
  logic doneR;
  logic modIsReg;
  logic latReached;

  assign modIsReg   = (modField == MOD_REGISTER);
  assign latReached = ({1'b0, latCnt} + 1'b1) >= {1'b0, latTarget};

  always_comb begin
    ctl      = '0;
    memReq   = 1'b0;
    nxtState = state;
    unique case (state)
      S_IDLE: begin
        if (start) begin
          ctl.loadOp = 1'b1;
          nxtState   = modIsReg ? S_REPORT : S_ISSUE_LO;
        end
      end
      S_ISSUE_LO: begin
        memReq   = 1'b1;
        nxtState = S_WAIT_LO;
      end
      S_WAIT_LO: begin
        if (memValid) begin
          if (memAbort) begin
            ctl.setAbort = 1'b1;
            nxtState     = S_IDLE;
          end else begin
            ctl.captureLo = 1'b1;
            nxtState      = S_ISSUE_HI;
          end
        end
      end
      S_ISSUE_HI: begin
        memReq     = 1'b1;
        ctl.selHi  = 1'b1;
        nxtState   = S_WAIT_HI;
      end
      S_WAIT_HI: begin
        ctl.selHi = 1'b1;
        if (memValid) begin
          if (memAbort) begin
            ctl.setAbort = 1'b1;
            nxtState     = S_IDLE;
          end else begin
            ctl.captureHi = 1'b1;
            nxtState      = S_SETTLE;
          end
        end
      end
      S_SETTLE: begin
        if (latReached) begin
          ctl.setVerdict = 1'b1;
          nxtState       = S_IDLE;
        end
      end
      S_REPORT: begin
        ctl.setIllegal = 1'b1;
        nxtState       = S_IDLE;
      end
      default: nxtState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= S_IDLE;
      doneR     <= 1'b0;
      latCnt    <= '0;
      latTarget <= SLOW_CNT;
    end else begin
      state <= nxtState;
      doneR <= (state != S_IDLE) && (nxtState == S_IDLE);
      if (state == S_IDLE) begin
        latCnt <= '0;
        if (start) latTarget <= fastMode ? FAST_CNT : SLOW_CNT;
      end else if (latCnt != CNT_MAX) begin
        latCnt <= latCnt + 1'b1;
      end
    end
  end

  assign busy = (state != S_IDLE);
  assign done = doneR;

  // R1: a register-form operand goes straight to reporting, no read issued
  p_reg_form_r1: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_IDLE && start && modIsReg) |=> (state == S_REPORT && !memReq));

  // R2: every request is a single-cycle strobe
  p_req_pulse_r2: assert property (@(posedge clk) disable iff (!rstN)
    memReq |=> !memReq);

  // R5: the verdict is held back until the latency window has elapsed
  p_min_latency_r5: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_SETTLE && !latReached) |=> (state == S_SETTLE));

endmodule

// File: rtl/bcu_datapath.sv
module bcu_datapath
  import bcu_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  bcuCtl_t           ctl,
  input  logic              opWide,
  input  logic [ADDR_W-1:0] effAddr,
  input  logic [DATA_W-1:0] indexVal,
  input  logic [DATA_W-1:0] memData,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memWide,
  output logic              passOk,
  output logic              boundTrap,
  output logic              illegalOp,
  output logic              abortOut,
  output logic [7:0]        trapVector
);

  localparam int HALF_W = DATA_W / 2;
  localparam logic [ADDR_W-1:0] NARROW_STEP = ADDR_W'(HALF_W / 8);
  localparam logic [ADDR_W-1:0] WIDE_STEP   = ADDR_W'(DATA_W / 8);

  logic [ADDR_W-1:0] eaR;
  logic [DATA_W-1:0] idxR, loR, hiR;
  logic              wideR;
  logic passR, trapR, illR, abtR;

  logic signed [DATA_W-1:0] idxS, loS, hiS;
  logic belowLo, aboveHi;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      eaR   <= '0;
      idxR  <= '0;
      loR   <= '0;
      hiR   <= '0;
      wideR <= 1'b0;
    end else begin
      if (ctl.loadOp) begin
        eaR   <= effAddr;
        idxR  <= indexVal;
        wideR <= opWide;
      end
      if (ctl.captureLo) loR <= memData;
      if (ctl.captureHi) hiR <= memData;
    end
  end

  assign memAddr = eaR + (ctl.selHi ? (wideR ? WIDE_STEP : NARROW_STEP) : '0);
  assign memWide = wideR;

  // operand-width sign handling
  always_comb begin
    if (wideR) begin
      idxS = idxR;
      loS  = loR;
      hiS  = hiR;
    end else begin
      idxS = {{(DATA_W-HALF_W){idxR[HALF_W-1]}}, idxR[HALF_W-1:0]};
      loS  = {{(DATA_W-HALF_W){loR[HALF_W-1]}},  loR[HALF_W-1:0]};
      hiS  = {{(DATA_W-HALF_W){hiR[HALF_W-1]}},  hiR[HALF_W-1:0]};
    end
  end

  assign belowLo = idxS < loS;
  assign aboveHi = idxS > hiS;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      passR <= 1'b0;
      trapR <= 1'b0;
      illR  <= 1'b0;
      abtR  <= 1'b0;
    end else if (ctl.loadOp) begin
      passR <= 1'b0;
      trapR <= 1'b0;
      illR  <= 1'b0;
      abtR  <= 1'b0;
    end else begin
      if (ctl.setIllegal) illR <= 1'b1;
      if (ctl.setAbort)   abtR <= 1'b1;
      if (ctl.setVerdict) begin
        trapR <= belowLo | aboveHi;
        passR <= ~(belowLo | aboveHi);
      end
    end
  end

  assign passOk     = passR;
  assign boundTrap  = trapR;
  assign illegalOp  = illR;
  assign abortOut   = abtR;
  assign trapVector = trapR ? RANGE_VECTOR : 8'd0;

  // R2: the upper-limit read address sits one operand width above the lower one
  p_hi_offset_r2: assert property (@(posedge clk) disable iff (!rstN)
    ctl.captureLo |=> (memAddr == loAddrPlusStep()));

  function automatic logic [ADDR_W-1:0] loAddrPlusStep();
    return eaR + (wideR ? WIDE_STEP : NARROW_STEP);
  endfunction

endmodule

// File: rtl/bound_check_unit.sv
module bound_check_unit
  import bcu_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 32,
  parameter int SLOW_LAT = 10,
  parameter int FAST_LAT = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              opWide,
  input  logic              fastMode,
  input  logic [1:0]        modField,
  input  logic [ADDR_W-1:0] effAddr,
  input  logic [DATA_W-1:0] indexVal,
  output logic              memReq,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memWide,
  input  logic              memValid,
  input  logic              memAbort,
  input  logic [DATA_W-1:0] memData,
  output logic              busy,
  output logic              done,
  output logic              passOk,
  output logic              boundTrap,
  output logic              illegalOp,
  output logic              abortOut,
  output logic [7:0]        trapVector
);

  bcuCtl_t ctl;

  bcu_ctrl #(.SLOW_LAT(SLOW_LAT), .FAST_LAT(FAST_LAT)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .modField(modField),
    .fastMode(fastMode), .memValid(memValid), .memAbort(memAbort),
    .ctl(ctl), .memReq(memReq), .busy(busy), .done(done)
  );

  bcu_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .opWide(opWide), .effAddr(effAddr),
    .indexVal(indexVal), .memData(memData), .memAddr(memAddr),
    .memWide(memWide), .passOk(passOk), .boundTrap(boundTrap),
    .illegalOp(illegalOp), .abortOut(abortOut), .trapVector(trapVector)
  );

  // R8: one outcome per completion
  p_one_outcome_r8: assert property (@(posedge clk) disable iff (!rstN)
    done |-> $onehot({passOk, boundTrap, illegalOp, abortOut}));

  // R7: busy only drops together with a completion pulse
  p_busy_release_r7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> done);

  // R4: a range trap carries its vector
  p_trap_vector_r4: assert property (@(posedge clk) disable iff (!rstN)
    (done && boundTrap) |-> (trapVector == RANGE_VECTOR));

endmodule

// File: tb/tb_bound_check_unit.sv
module tb_bound_check_unit;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic        opWide = 1'b0;
  logic        fastMode = 1'b0;
  logic [1:0]  modField = 2'b00;
  logic [31:0] effAddr = '0;
  logic [31:0] indexVal = '0;
  logic        memReq, memWide, memValid, memAbort;
  logic [31:0] memAddr, memData;
  logic        busy, done, passOk, boundTrap, illegalOp, abortOut;
  logic [7:0]  trapVector;

  always #5 clk = ~clk;

  bound_check_unit dut (
    .clk(clk), .rstN(rstN), .start(start), .opWide(opWide), .fastMode(fastMode),
    .modField(modField), .effAddr(effAddr), .indexVal(indexVal),
    .memReq(memReq), .memAddr(memAddr), .memWide(memWide),
    .memValid(memValid), .memAbort(memAbort), .memData(memData),
    .busy(busy), .done(done), .passOk(passOk), .boundTrap(boundTrap),
    .illegalOp(illegalOp), .abortOut(abortOut), .trapVector(trapVector)
  );

  // ---- memory model ----
  logic [31:0] curEa = '0, curLo = '0, curHi = '0;
  logic        curWide = 1'b0;
  int          abortAt = 0;
  int          respDelay = 0;
  logic        clrReq = 1'b0;
  int          reqCount = 0;
  logic [31:0] reqAddr [4];
  logic        wideSeen = 1'b0;
  logic        pendOn = 1'b0;
  int          pendWait = 0;
  int          pendIdx = 0;
  logic [31:0] pendAddr = '0;

  function automatic logic [31:0] pickData(logic [31:0] a);
    if (a == curEa) return curLo;
    if (a == curEa + (curWide ? 32'd4 : 32'd2)) return curHi;
    return 32'hDEAD_BEEF;
  endfunction

  initial begin
    memValid = 1'b0; memAbort = 1'b0; memData = '0;
    for (int i = 0; i < 4; i++) reqAddr[i] = '0;
  end

  always @(posedge clk) begin
    memValid <= 1'b0;
    memAbort <= 1'b0;
    if (clrReq) begin
      reqCount <= 0;
      pendOn   <= 1'b0;
    end else if (memReq) begin
      if (reqCount < 4) reqAddr[reqCount] <= memAddr;
      wideSeen <= memWide;
      reqCount <= reqCount + 1;
      if (respDelay == 0) begin
        memValid <= 1'b1;
        memData  <= pickData(memAddr);
        memAbort <= (reqCount + 1 == abortAt);
      end else begin
        pendOn   <= 1'b1;
        pendWait <= respDelay;
        pendAddr <= memAddr;
        pendIdx  <= reqCount + 1;
      end
    end else if (pendOn) begin
      if (pendWait <= 1) begin
        pendOn   <= 1'b0;
        memValid <= 1'b1;
        memData  <= pickData(pendAddr);
        memAbort <= (pendIdx == abortAt);
      end else begin
        pendWait <= pendWait - 1;
      end
    end
  end

  // ---- checking ----
  int nChecks = 0;
  int nFails  = 0;

  task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // lat: edges from the start edge to the edge raising done
  task automatic runOp(input logic wide, input logic fast, input logic [1:0] md,
                       input logic [31:0] ea, input logic [31:0] idx,
                       input logic [31:0] lo, input logic [31:0] hi,
                       input int abAt, input int dly, input int midStart,
                       output int lat, output logic busySeen);
    @(negedge clk);
    curEa = ea; curLo = lo; curHi = hi; curWide = wide;
    abortAt = abAt; respDelay = dly;
    opWide = wide; fastMode = fast; modField = md; effAddr = ea; indexVal = idx;
    clrReq = 1'b1;
    @(negedge clk);
    clrReq = 1'b0;
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    busySeen = busy;
    lat = 0;
    while (!done && lat < 80) begin
      if (midStart != 0 && lat == midStart) begin
        start = 1'b1; modField = 2'b11;
      end else begin
        start = 1'b0;
      end
      @(posedge clk);
      lat++;
      @(negedge clk);
      if (!done) busySeen = busySeen & busy;
    end
    start = 1'b0;
  endtask

  typedef struct packed {
    logic        wide;
    logic        fast;
    logic [31:0] ea;
    logic [31:0] idx;
    logic [31:0] lo;
    logic [31:0] hi;
    logic        expTrap;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b0, 32'h0000_0100, 32'h0000_0005, 32'h0000_0000, 32'h0000_000A, 1'b0},
    '{1'b0, 1'b1, 32'h0000_0200, 32'h0000_FFFD, 32'h7777_FFF0, 32'h0000_0005, 1'b0},
    '{1'b0, 1'b0, 32'h0000_0300, 32'h0000_0010, 32'h0000_0010, 32'h0000_0020, 1'b0},
    '{1'b0, 1'b1, 32'h0000_0400, 32'h0000_0020, 32'h0000_0010, 32'h0000_0020, 1'b0},
    '{1'b0, 1'b0, 32'h0000_0500, 32'h0000_0021, 32'h0000_0010, 32'h0000_0020, 1'b1},
    '{1'b1, 1'b0, 32'h0000_0600, 32'h0000_000F, 32'h0000_0010, 32'h0000_0020, 1'b1},
    '{1'b1, 1'b1, 32'h0000_0700, 32'h8000_0000, 32'h8000_0000, 32'h7FFF_FFFF, 1'b0},
    '{1'b1, 1'b0, 32'h0000_0800, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 32'h7FFF_FFFE, 1'b1},
    '{1'b0, 1'b1, 32'h0000_0900, 32'h1234_0005, 32'hAAAA_0000, 32'h5555_000A, 1'b0},
    '{1'b1, 1'b1, 32'h0000_0A00, 32'hFFFF_FFFE, 32'hFFFF_FFFF, 32'h0000_0000, 1'b1}
  };

  logic finished = 1'b0;

  initial begin
    #(200000 * 10);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    int lat;
    logic bs;

    // reset state (R8)
    repeat (3) @(negedge clk);
    check({busy, done, memReq, passOk, boundTrap, illegalOp, abortOut} == '0,
          "R8 reset outputs", {25'd0, busy, done, memReq, passOk, boundTrap, illegalOp, abortOut}, 0);
    rstN = 1'b1;
    @(negedge clk);

    // table walk
    for (int v = 0; v < NV; v++) begin
      int expLat;
      expLat = VECS[v].fast ? 7 : 10;
      runOp(VECS[v].wide, VECS[v].fast, 2'b00, VECS[v].ea, VECS[v].idx,
            VECS[v].lo, VECS[v].hi, 0, 0, 0, lat, bs);
      check(lat == expLat, "R5 latency", lat, expLat);
      check(reqCount == 2, "R2 request count", reqCount, 2);
      check(reqAddr[0] == VECS[v].ea, "R2 lower address", reqAddr[0], VECS[v].ea);
      check(reqAddr[1] == VECS[v].ea + (VECS[v].wide ? 32'd4 : 32'd2),
            "R2 upper address", reqAddr[1], VECS[v].ea + (VECS[v].wide ? 32'd4 : 32'd2));
      check(wideSeen == VECS[v].wide, "R2 read size", wideSeen, VECS[v].wide);
      check(boundTrap == VECS[v].expTrap, "R3 R4 trap verdict", boundTrap, VECS[v].expTrap);
      check(passOk == !VECS[v].expTrap, "R4 pass verdict", passOk, !VECS[v].expTrap);
      check(trapVector == (VECS[v].expTrap ? 8'd5 : 8'd0), "R4 vector", trapVector,
            VECS[v].expTrap ? 32'd5 : 32'd0);
      check(bs == 1'b1, "R7 busy during operation", bs, 1);
      check(done && !busy, "R7 busy low at done", busy, 0);
    end

    // R1: register-form operand
    runOp(1'b1, 1'b0, 2'b11, 32'h40, 32'h5, 32'h0, 32'hA, 0, 0, 0, lat, bs);
    check(lat == 1, "R1 illegal latency", lat, 1);
    check(illegalOp == 1'b1, "R1 illegal flag", illegalOp, 1);
    check(reqCount == 0, "R1 no memory access", reqCount, 0);
    check(!passOk && !boundTrap, "R1 no verdict", {passOk, boundTrap}, 0);

    // R6: abort on lower read
    runOp(1'b0, 1'b0, 2'b01, 32'h80, 32'h5, 32'h0, 32'hA, 1, 0, 0, lat, bs);
    check(lat == 2, "R6 abort lo latency", lat, 2);
    check(abortOut == 1'b1, "R6 abort lo flag", abortOut, 1);
    check(reqCount == 1, "R6 abort lo no second read", reqCount, 1);
    check(!passOk && !boundTrap, "R6 abort lo no verdict", {passOk, boundTrap}, 0);

    // R6: abort on upper read
    runOp(1'b1, 1'b1, 2'b10, 32'h90, 32'h50, 32'h0, 32'hA, 2, 0, 0, lat, bs);
    check(lat == 4, "R6 abort hi latency", lat, 4);
    check(abortOut == 1'b1, "R6 abort hi flag", abortOut, 1);
    check(reqCount == 2, "R6 abort hi reads", reqCount, 2);
    check(!passOk && !boundTrap, "R6 abort hi no verdict", {passOk, boundTrap}, 0);

    // R5: slow memory stretches the result beyond the fixed latency
    runOp(1'b0, 1'b1, 2'b00, 32'hA0, 32'h3, 32'h1, 32'h3, 0, 5, 0, lat, bs);
    check(lat == 15, "R5 slow memory latency", lat, 15);
    check(passOk == 1'b1, "R5 slow memory verdict", passOk, 1);

    // R7: start while busy is ignored (injects a register-form start mid-run)
    runOp(1'b0, 1'b0, 2'b00, 32'hB0, 32'h30, 32'h0, 32'h10, 0, 0, 3, lat, bs);
    check(lat == 10, "R7 restart ignored latency", lat, 10);
    check(boundTrap && !illegalOp, "R7 restart ignored outcome", {boundTrap, illegalOp}, 32'h2);
    check(reqCount == 2, "R7 restart ignored reads", reqCount, 2);

    // R8: outcome held, done is a pulse
    repeat (5) @(negedge clk);
    check(done == 1'b0, "R8 done pulse", done, 0);
    check(boundTrap == 1'b1 && trapVector == 8'd5, "R8 outcome held", {boundTrap, trapVector}, 32'h105);
    check(reqCount == 2 && !busy, "R8 idle after completion", reqCount, 2);

    finished = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule